// File: doc/BRIEF.md
# Four-Way Unified Cache Tag Controller

This block holds the tag and valid state for a physically addressed cache of four ways. Each way covers 2 KiB in 128 lines of 16 bytes. The one cache serves instruction fetches and data accesses alike. A requester offers a 32-bit physical address, together with a read or write flag, on a valid/ready request channel. One cycle after the request is accepted, the block returns a registered response on a valid/ready response channel. The response says whether the access hit, which way it selected, and whether a new line was allocated.

When a read misses, the block writes the new tag into a victim way in the same cycle that it accepts the request. The victim is the lowest-numbered invalid way if the set has one; otherwise a three-bit tree pseudo-LRU held for each set picks it. Writes follow a write-through policy, so lines never become dirty. A write hit only refreshes the replacement state, and a write miss leaves both the tags and the replacement state alone. A plain flush input clears every valid bit in one clock. The data array and the external bus sit outside this block.

Back-pressure works through a single response register. `req_ready` is high when the response register is empty, or when it is being drained in the same cycle (`rsp_ready` high), and flush is low. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `rsp_valid` is high and `rsp_ready` is low, every response field holds its value.

Top module: `utag_cache_ctrl`

## Requirements
- R1: The address is split as byte offset = bits 3:0, set index = bits 10:4 and tag = bits 31:11. The offset has no effect on the result, and sets are independent of each other.
- R2: A hit needs a valid line in the indexed set whose stored tag equals the address tag. At most one way ever hits, and a hit reports `rsp_hit`=1 with `rsp_way` set to the hitting way.
- R3: A read miss when the set has an invalid way allocates the lowest-numbered invalid way. The response then shows `rsp_hit`=0, `rsp_alloc`=1 and `rsp_way` set to that way, and a later read of the same address hits that way.
- R4: A read miss when all four ways are valid evicts the way chosen by the set's tree bits {b2,b1,b0}. If b0=0 the victim is way b1 (way 0 or 1); if b0=1 the victim is way 2+b2.
- R5: Each read hit, write hit and read-miss fill of way w updates the tree bits. For w=0 the update is b0=1,b1=1; for w=1 it is b0=1,b1=0; for w=2 it is b0=0,b2=1; for w=3 it is b0=0,b2=0.
- R6: A write miss returns `rsp_hit`=0, `rsp_alloc`=0 and `rsp_way`=0. It changes neither the tags, the valid bits nor the tree bits.
- R7: A cycle with `flush` high clears all valid bits by the next clock, and `req_ready` is low during that cycle.
- R8: `req_ready` is high exactly when the response register is empty or being drained that cycle, and `flush` is low. A request is accepted only on such a cycle.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid`, `rsp_hit`, `rsp_way` and `rsp_alloc` stay unchanged.
- R10: After reset no line is valid, all tree bits are 0, `rsp_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | Access hit |
| rsp_way | output | 2 | Hit or allocated way |
| rsp_alloc | output | 1 | Read miss installed a tag |

## Verification
The assertions assume that the requester keeps `req_addr` and `req_write` steady while a request waits, and that the response consumer never expects a field to change while it stalls the channel. The one-hot hit check assumes that a tag only ever enters a set through a read-miss fill, so no tag can be stored twice in the same set. The stimulus drives every request on a falling edge and withdraws it after one accepting edge. It raises `flush` only while no request is offered, and it drops `rsp_ready` only in the dedicated back-pressure scenario.

// File: rtl/utag_pkg.sv
package utag_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;
  localparam int TREE_W = WAYS - 1;
endpackage

// File: rtl/utag_way_store.sv
module utag_way_store #(
  parameter int SET_W = 7,
  parameter int TAG_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic             lk_valid,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int SETS = 1 << SET_W;

  logic [TAG_W-1:0] tag_q [SETS];
  logic [SETS-1:0]  valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_set] <= wr_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid_q <= '0;
    else if (flush)  valid_q <= '0;
    else if (wr_en)  valid_q[wr_set] <= 1'b1;
  end

  assign lk_valid = valid_q[lk_set];
  assign lk_hit   = lk_valid && (tag_q[lk_set] == lk_tag);

  // R7: flush empties the way on the next edge
  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
  // R3: a fill leaves the written line valid
  p_fill_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> valid_q[$past(wr_set)]);
endmodule

// File: rtl/utag_plru.sv
module utag_plru
  import utag_pkg::*;
#(
  parameter int SET_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] victim,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way
);
  localparam int SETS = 1 << SET_W;

  logic [TREE_W-1:0] tree_q [SETS];
  logic [TREE_W-1:0] cur;
  logic [TREE_W-1:0] nxt;

  assign cur    = tree_q[rd_set];
  assign victim = cur[0] ? {1'b1, cur[2]} : {1'b0, cur[1]};

  always_comb begin
    nxt = tree_q[upd_set];
    if (!upd_way[1]) begin
      nxt[0] = 1'b1;
      nxt[1] = ~upd_way[0];
    end else begin
      nxt[0] = 1'b0;
      nxt[2] = ~upd_way[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (upd_en) begin
      tree_q[upd_set] <= nxt;
    end
  end

  // R5: the way just touched is never the next victim of that set
  p_touched_not_victim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && rd_set == upd_set) |=> ($stable(rd_set) -> (victim != $past(upd_way))));
endmodule

// File: rtl/utag_cache_ctrl.sv
module utag_cache_ctrl
  import utag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 4,
  parameter int SET_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_alloc
);
  localparam int TAG_W = ADDR_W - OFFS_W - SET_W;

  logic [SET_W-1:0] a_set;
  logic [TAG_W-1:0] a_tag;
  logic [WAYS-1:0]  hit_vec;
  logic [WAYS-1:0]  val_vec;
  logic [WAYS-1:0]  fill_vec;
  logic             any_hit, any_inv, accept, fill;
  logic [WAY_W-1:0] hit_way, inv_way, tree_way, victim, touch_way;

  assign a_set = req_addr[OFFS_W +: SET_W];
  assign a_tag = req_addr[ADDR_W-1 -: TAG_W];

  assign req_ready = (!rsp_valid || rsp_ready) && !flush;
  assign accept    = req_valid && req_ready;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    utag_way_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_set(a_set), .lk_tag(a_tag),
      .lk_hit(hit_vec[w]), .lk_valid(val_vec[w]),
      .wr_en(fill_vec[w]), .wr_set(a_set), .wr_tag(a_tag)
    );
    assign fill_vec[w] = fill && (victim == WAY_W'(w));
  end

  always_comb begin
    hit_way = '0;
    inv_way = '0;
    any_inv = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (!val_vec[w]) begin
        inv_way = WAY_W'(w);
        any_inv = 1'b1;
      end
    end
  end

  assign any_hit   = |hit_vec;
  assign victim    = any_inv ? inv_way : tree_way;
  assign fill      = accept && !req_write && !any_hit;
  assign touch_way = any_hit ? hit_way : victim;

  utag_plru #(.SET_W(SET_W)) u_plru (
    .clk(clk), .rst_n(rst_n),
    .rd_set(a_set), .victim(tree_way),
    .upd_en(accept && (any_hit || fill)),
    .upd_set(a_set), .upd_way(touch_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_alloc <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= any_hit;
      rsp_way   <= (any_hit || fill) ? touch_way : '0;
      rsp_alloc <= fill;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R2: no two ways match one lookup
  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R9: a stalled response is frozen
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) &&
                                   $stable(rsp_way) && $stable(rsp_alloc)));
  // R6: writes never allocate
  p_write_no_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_alloc);
  // R3: allocation only reported on a miss
  p_alloc_is_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_alloc) |-> !rsp_hit);
endmodule

// File: tb/sim_utag_cache_ctrl.sv
module sim_utag_cache_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [1:0]  rsp_way;
  logic        rsp_alloc;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  utag_cache_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_alloc(rsp_alloc)
  );

  function automatic logic [31:0] mk(input int tag, input int set, input int off);
    return {21'(tag), 7'(set), 4'(off)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // expect: hit, way, alloc
  task automatic access(input string req, input logic [31:0] a, input logic w,
                        input int e_hit, input int e_way, input int e_alloc);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_write = w;
    chk({req, " ready"}, int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, int'(rsp_valid), 1);
    chk({req, " hit"},   int'(rsp_hit),   e_hit);
    chk({req, " way"},   int'(rsp_way),   e_way);
    chk({req, " alloc"}, int'(rsp_alloc), e_alloc);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10 rsp_valid", int'(rsp_valid), 0);
    chk("R10 req_ready", int'(req_ready), 1);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 4; i++) access("R3 fill lowest invalid", mk(10+i, 5, 0), 1'b0, 0, i, 1);
    for (int i = 0; i < 4; i++) access("R1 R2 hit any offset", mk(10+i, 5, 7), 1'b0, 1, i, 0);
  endtask

  task automatic t_plru;
    access("R4 victim way0", mk(14, 5, 0), 1'b0, 0, 0, 1);
    access("R4 evicted tag misses to way2", mk(10, 5, 0), 1'b0, 0, 2, 1);
  endtask

  task automatic t_write_hit;
    access("R5 write hit", mk(11, 5, 3), 1'b1, 1, 1, 0);
    access("R5 victim after write hit", mk(15, 5, 0), 1'b0, 0, 3, 1);
  endtask

  task automatic t_write_miss;
    access("R6 write miss", mk(20, 5, 0), 1'b1, 0, 0, 0);
    access("R6 no alloc no tree change", mk(20, 5, 0), 1'b0, 0, 0, 1);
    access("R6 tag now resident", mk(20, 5, 9), 1'b0, 1, 0, 0);
  endtask

  task automatic t_sets;
    access("R1 other set independent", mk(10, 6, 0), 1'b0, 0, 0, 1);
    access("R1 set5 untouched", mk(10, 5, 15), 1'b0, 1, 2, 0);
  endtask

  task automatic t_flush;
    @(negedge clk);
    flush = 1'b1;
    #1 chk("R7 ready low in flush", int'(req_ready), 0);
    @(negedge clk);
    flush = 1'b0;
    access("R7 miss after flush set5", mk(11, 5, 0), 1'b0, 0, 0, 1);
    access("R7 miss after flush set6", mk(10, 6, 0), 1'b0, 0, 0, 1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    req_addr  = mk(11, 5, 0);
    req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 taken", int'(rsp_valid), 1);
    chk("R8 ready low when stalled", int'(req_ready), 0);
    req_valid = 1'b1;
    req_addr  = mk(40, 5, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 held valid", int'(rsp_valid), 1);
    chk("R9 held hit", int'(rsp_hit), 1);
    chk("R9 held way", int'(rsp_way), 0);
    chk("R8 no accept while stalled", int'(rsp_alloc), 0);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 drained", int'(rsp_valid), 0);
    access("R8 stalled request was dropped", mk(40, 5, 0), 1'b0, 0, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_plru();
    t_write_hit();
    t_write_miss();
    t_sets();
    t_flush();
    t_backpressure();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule